// File: doc/BRIEF.md
# ARINC 429 Transmit Queue

This block takes 32-bit ARINC 429 words from a 16-bit host bus, queues them, and sends them one at a time as a return-to-zero, three-level line code. A word enters in two strobed halves: a low strobe captures bits 1 to 16, and a high strobe supplies bits 17 to 32 and commits the whole word to a 32-entry queue. While the enable input is high, queued words leave the queue one at a time. Each is shifted out starting with ARINC bit 1, and a fixed null gap separates consecutive words.

Each bit time is split into a data half, where the line shows a one or a zero level, and a null half. The bit time is 10 master clocks at the fast rate and 80 at the slow rate. The gap between words is four bit times. Bit 32 can be replaced by a generated odd or even parity bit, or it can be sent as loaded. A test input holds the line at null. The input side has no stall: the full flag is the only back-pressure signal, and a word committed while the queue is full is dropped. The line outputs have no handshake and follow the bit timer exactly.

Top module: `a429_tx_queue`

## Requirements
- R1: `load_lo` latches `load_data` as word bits [15:0]. `load_hi` joins `load_data` as bits [31:16] and commits the word. Word bit 0 (ARINC bit 1) goes on the line first, and bit 31 goes last.
- R2: The queue holds 32 words and sends them in the order they were loaded. `full_o` is high at 32 words. A commit while the queue is full is discarded.
- R3: `half_room_o` is high while the queue holds fewer than 16 words and low at 16 or more.
- R4: `ready_o` is low in the cycle after a commit. It is high only when the queue is empty and no bit of a word is still on the line, so it rises in the first gap cycle after bit 32 of the last word.
- R5: With `slow_rate` low, each bit shows its data level for 5 clocks and then null for 5 clocks. The null gap between words lasts 40 clocks.
- R6: With `slow_rate` high, each bit shows data for 40 clocks and then null for 40 clocks. The gap lasts 320 clocks. The rate is sampled when a word leaves the queue.
- R7: With `parity_on` high, bit 32 is replaced. When `parity_even` is 0 it gives odd total parity over the 32 bits, and when `parity_even` is 1 it gives even total parity. With `parity_on` low, all 32 bits are sent unchanged.
- R8: A word starts only while `tx_enable` is high and the queue is not empty. While enable stays high, queued words go out back to back with one gap between them. If enable drops during a word, that word finishes and no further word starts.
- R9: While `force_null` is high, both line outputs are low, and words continue to be consumed on the normal schedule.
- R10: When `rst_n` is low, transmission stops at once, the line goes null, the queue empties, `ready_o` and `half_room_o` go high, and `full_o` goes low.
- R11: The line code is as follows: a one puts `line_one` high, a zero puts `line_zero` high, and null leaves both low. The two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_data | input | 16 | Host data half |
| load_lo | input | 1 | Strobe that latches the low half |
| load_hi | input | 1 | Strobe that supplies the high half and commits the word |
| tx_enable | input | 1 | Allows words to start |
| slow_rate | input | 1 | 1 selects the 80-clock bit time |
| parity_on | input | 1 | 1 replaces bit 32 with parity |
| parity_even | input | 1 | Parity sense: 0 odd, 1 even |
| force_null | input | 1 | Holds the line at null |
| line_one | output | 1 | Line at one level |
| line_zero | output | 1 | Line at zero level |
| ready_o | output | 1 | Queue empty and line idle |
| half_room_o | output | 1 | Fewer than 16 words queued |
| full_o | output | 1 | 32 words queued |

## Verification
Almost any wrong internal state shows up on the line within one word. A bad read pointer sends words in the wrong order or repeats one, which is visible 10 or 80 clocks per bit after the enable rises. A miscounted half-bit or gap timer changes the number of data or null cycles, and the sampled level width exposes this at the first bit. An error in the occupancy counter shows up in the flags on the cycle after the commit that crosses 16 or 32 words. It also appears when a word that should have been dropped reaches the line.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  localparam int ARINC_BITS = 32;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_BIT  = 2'd1,
    TX_GAP  = 2'd2
  } tx_state_e;

  // Replace bit 32 with parity when requested; odd sense when even_sense is 0
  function automatic logic [ARINC_BITS-1:0] seal_word(
    input logic [ARINC_BITS-1:0] w,
    input logic                  par_on,
    input logic                  even_sense
  );
    logic [ARINC_BITS-1:0] r;
    r = w;
    if (par_on) r[ARINC_BITS-1] = (^w[ARINC_BITS-2:0]) ^ ~even_sense;
    return r;
  endfunction
endpackage

// File: rtl/a429_tx_assembler.sv
module a429_tx_assembler #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_lo,
  input  logic              load_hi,
  input  logic [HALF_W-1:0] load_data,
  output logic              word_valid,
  output logic [2*HALF_W-1:0] word
);
  logic [HALF_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lo_q <= '0;
    else if (load_lo) lo_q <= load_data;
  end

  assign word_valid = load_hi;
  assign word       = {load_data, lo_q};
endmodule

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_data,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  row [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) row[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign rd_data = row[rd_ptr];
endmodule

// File: rtl/a429_tx_serializer.sv
module a429_tx_serializer
  import a429_tx_pkg::*;
#(
  parameter int FAST_HALF = 5,
  parameter int SLOW_HALF = 40,
  parameter int GAP_BITS  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_enable,
  input  logic                  slow_rate,
  input  logic                  parity_on,
  input  logic                  parity_even,
  input  logic                  force_null,
  input  logic                  word_avail,
  input  logic [ARINC_BITS-1:0] word_in,
  output logic                  pop,
  output logic                  busy,
  output logic                  line_one,
  output logic                  line_zero
);
  localparam int GAP_FAST = FAST_HALF * 2 * GAP_BITS;
  localparam int GAP_SLOW = SLOW_HALF * 2 * GAP_BITS;
  localparam int TW       = $clog2(GAP_SLOW + 1);
  localparam int IW       = $clog2(ARINC_BITS);

  tx_state_e             state;
  logic [ARINC_BITS-1:0] shreg;
  logic [IW-1:0]         bit_idx;
  logic                  null_ph;
  logic                  slow_q;
  logic [TW-1:0]         tick;
  logic [TW-1:0]         half_last, gap_last;
  logic                  at_gap_end, start, drive;

  assign half_last  = slow_q ? TW'(SLOW_HALF - 1) : TW'(FAST_HALF - 1);
  assign gap_last   = slow_q ? TW'(GAP_SLOW - 1)  : TW'(GAP_FAST - 1);
  assign at_gap_end = (state == TX_GAP) && (tick == gap_last);
  assign start      = tx_enable && word_avail && ((state == TX_IDLE) || at_gap_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= TX_IDLE;
      shreg   <= '0;
      bit_idx <= '0;
      null_ph <= 1'b0;
      slow_q  <= 1'b0;
      tick    <= '0;
    end else if (start) begin
      state   <= TX_BIT;
      shreg   <= seal_word(word_in, parity_on, parity_even);
      slow_q  <= slow_rate;
      bit_idx <= '0;
      null_ph <= 1'b0;
      tick    <= '0;
    end else begin
      case (state)
        TX_BIT: begin
          if (tick == half_last) begin
            tick <= '0;
            if (!null_ph) begin
              null_ph <= 1'b1;
            end else begin
              null_ph <= 1'b0;
              if (bit_idx == IW'(ARINC_BITS - 1)) begin
                state <= TX_GAP;
              end else begin
                bit_idx <= bit_idx + 1'b1;
                shreg   <= shreg >> 1;
              end
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
        TX_GAP: begin
          if (at_gap_end) begin
            state <= TX_IDLE;
            tick  <= '0;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: tick <= '0;
      endcase
    end
  end

  assign pop       = start;
  assign busy      = (state == TX_BIT);
  assign drive     = busy && !null_ph && !force_null;
  assign line_one  = drive && shreg[0];
  assign line_zero = drive && !shreg[0];
endmodule

// File: rtl/a429_tx_queue.sv
module a429_tx_queue
  import a429_tx_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int FAST_HALF = 5,
  parameter int SLOW_HALF = 40,
  parameter int GAP_BITS  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] load_data,
  input  logic        load_lo,
  input  logic        load_hi,
  input  logic        tx_enable,
  input  logic        slow_rate,
  input  logic        parity_on,
  input  logic        parity_even,
  input  logic        force_null,
  output logic        line_one,
  output logic        line_zero,
  output logic        ready_o,
  output logic        half_room_o,
  output logic        full_o
);
  localparam int HALF_W = ARINC_BITS / 2;
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int HALF_N = DEPTH / 2;

  logic                  word_valid, wr_accept, pop, busy;
  logic [ARINC_BITS-1:0] word_in, head_word;
  logic [CW-1:0]         count;

  a429_tx_assembler #(.HALF_W(HALF_W)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_lo    (load_lo),
    .load_hi    (load_hi),
    .load_data  (load_data),
    .word_valid (word_valid),
    .word       (word_in)
  );

  assign full_o    = (count == CW'(DEPTH));
  assign wr_accept = word_valid && !full_o;

  a429_tx_fifo #(.W(ARINC_BITS), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_accept),
    .wr_data (word_in),
    .rd_en   (pop),
    .rd_data (head_word),
    .count   (count)
  );

  a429_tx_serializer #(
    .FAST_HALF (FAST_HALF),
    .SLOW_HALF (SLOW_HALF),
    .GAP_BITS  (GAP_BITS)
  ) u_ser (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_enable   (tx_enable),
    .slow_rate   (slow_rate),
    .parity_on   (parity_on),
    .parity_even (parity_even),
    .force_null  (force_null),
    .word_avail  (count != '0),
    .word_in     (head_word),
    .pop         (pop),
    .busy        (busy),
    .line_one    (line_one),
    .line_zero   (line_zero)
  );

  assign ready_o     = (count == '0) && !busy;
  assign half_room_o = (count < CW'(HALF_N));
endmodule

// File: rtl/a429_tx_checker.sv
module a429_tx_checker #(
  parameter int DEPTH = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tx_enable,
  input logic                       force_null,
  input logic                       line_one,
  input logic                       line_zero,
  input logic                       ready_o,
  input logic                       half_room_o,
  input logic                       full_o,
  input logic                       wr_accept,
  input logic                       pop,
  input logic                       busy,
  input logic [$clog2(DEPTH+1)-1:0] count
);
  assert_one_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_one && line_zero));

  assert_forced_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_null |-> !(line_one || line_zero));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH+1))'(DEPTH));

  assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !pop) |=> full_o);

  assert_full_not_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !half_room_o);

  assert_commit_clears_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !ready_o);

  assert_start_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_enable));
endmodule

bind a429_tx_queue a429_tx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_enable   (tx_enable),
  .force_null  (force_null),
  .line_one    (line_one),
  .line_zero   (line_zero),
  .ready_o     (ready_o),
  .half_room_o (half_room_o),
  .full_o      (full_o),
  .wr_accept   (wr_accept),
  .pop         (pop),
  .busy        (busy),
  .count       (count)
);

// File: tb/a429_tx_queue_tb.sv
`timescale 1ns/1ps
module a429_tx_queue_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] load_data = '0;
  logic        load_lo = 1'b0, load_hi = 1'b0, tx_enable = 1'b0;
  logic        slow_rate = 1'b0, parity_on = 1'b0, parity_even = 1'b0, force_null = 1'b0;
  logic        line_one, line_zero, ready_o, half_room_o, full_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  a429_tx_queue u_dut (
    .clk(clk), .rst_n(rst_n), .load_data(load_data), .load_lo(load_lo), .load_hi(load_hi),
    .tx_enable(tx_enable), .slow_rate(slow_rate), .parity_on(parity_on),
    .parity_even(parity_even), .force_null(force_null), .line_one(line_one),
    .line_zero(line_zero), .ready_o(ready_o), .half_room_o(half_room_o), .full_o(full_o)
  );

  // {slow, parity_on, parity_even, pad, word, expected line word}
  localparam logic [67:0] VEC [8] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0001, 32'h0000_0001},
    {1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0001, 32'h8000_0001},
    {1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0003, 32'h8000_0003},
    {1'b0, 1'b1, 1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000},
    {1'b0, 1'b1, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_0000},
    {1'b0, 1'b0, 1'b1, 1'b0, 32'h1234_5678, 32'h1234_5678},
    {1'b0, 1'b1, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk); load_data = w[15:0];  load_lo = 1'b1;
    @(negedge clk); load_lo = 1'b0; load_data = w[31:16]; load_hi = 1'b1;
    @(negedge clk); load_hi = 1'b0;
  endtask

  // Receive one word; counts timing faults in bad. Ends on the last null cycle of bit 32.
  task automatic grab(input int half, output logic [31:0] w, output int bad);
    int waited = 0;
    bad = 0; w = '0;
    while (!(line_one || line_zero) && waited < 5000) begin
      @(negedge clk); waited++;
    end
    if (waited >= 5000) begin bad = 1000; return; end
    for (int i = 0; i < 32; i++) begin
      automatic logic lvl = line_one;
      if (line_one == line_zero) bad++;
      w[i] = lvl;
      repeat (half - 1) @(negedge clk);
      if (line_one != lvl || line_zero != !lvl) bad++;
      @(negedge clk);
      if (line_one || line_zero) bad++;
      repeat (half - 1) @(negedge clk);
      if (line_one || line_zero) bad++;
      if (i < 31) @(negedge clk);
    end
  endtask

  task automatic gap_len(output int n);
    n = 0;
    @(negedge clk);
    while (!(line_one || line_zero) && n < 2000) begin n++; @(negedge clk); end
  endtask

  task automatic quiet_for(input int cyc, output int act);
    act = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (line_one || line_zero) act++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] got;
    int bad, n, act;

    repeat (3) @(negedge clk);
    // R10: reset state
    chk(ready_o == 1'b1 && half_room_o == 1'b1 && full_o == 1'b0, "R10 reset flags",
        {29'd0, ready_o, half_room_o, full_o}, 32'd6);
    chk(!line_one && !line_zero, "R10 reset line null", {30'd0, line_one, line_zero}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Vector table: loading, parity modes, timing at both rates
    for (int v = 0; v < 8; v++) begin
      automatic int h = VEC[v][67] ? 40 : 5;
      slow_rate = VEC[v][67]; parity_on = VEC[v][66]; parity_even = VEC[v][65];
      push(VEC[v][63:32]);
      chk(ready_o == 1'b0, "R4 ready low after commit", {31'd0, ready_o}, 32'd0);
      tx_enable = 1'b1;
      grab(h, got, bad);
      chk(got == VEC[v][31:0], "R1 R7 line word", got, VEC[v][31:0]);
      chk(bad == 0, VEC[v][67] ? "R6 R11 slow bit timing" : "R5 R11 fast bit timing", bad, 0);
      chk(ready_o == 1'b0, "R4 ready low during bit 32", {31'd0, ready_o}, 32'd0);
      @(negedge clk);
      chk(ready_o == 1'b1, "R4 ready high at gap", {31'd0, ready_o}, 32'd1);
      tx_enable = 1'b0;
      repeat (8 * h + 10) @(negedge clk);
    end

    // R2 R3: fill queue, overflow dropped, order kept, fast gaps
    slow_rate = 1'b0; parity_on = 1'b0;
    for (int i = 0; i < 32; i++) begin
      push(32'hA500_0000 + i);
      if (i == 14) chk(half_room_o == 1'b1, "R3 half flag at 15", {31'd0, half_room_o}, 32'd1);
      if (i == 15) chk(half_room_o == 1'b0, "R3 half flag at 16", {31'd0, half_room_o}, 32'd0);
      if (i == 30) chk(full_o == 1'b0, "R2 not full at 31", {31'd0, full_o}, 32'd0);
    end
    chk(full_o == 1'b1, "R2 full at 32", {31'd0, full_o}, 32'd1);
    push(32'hDEAD_BEEF);
    chk(full_o == 1'b1, "R2 still full after dropped load", {31'd0, full_o}, 32'd1);
    tx_enable = 1'b1;
    for (int i = 0; i < 32; i++) begin
      grab(5, got, bad);
      chk(got == 32'hA500_0000 + i && bad == 0, "R2 queue order", got, 32'hA500_0000 + i);
      if (i < 31) begin
        gap_len(n);
        chk(n == 40, "R5 R8 fast word gap", n, 40);
      end
    end
    quiet_for(400, act);
    chk(act == 0, "R2 dropped word never sent", act, 0);
    chk(ready_o == 1'b1, "R4 ready after drain", {31'd0, ready_o}, 32'd1);
    tx_enable = 1'b0;

    // R6: slow gap
    slow_rate = 1'b1;
    push(32'h0F0F_0F0F); push(32'h3333_CCCC);
    tx_enable = 1'b1;
    grab(40, got, bad);
    chk(got == 32'h0F0F_0F0F && bad == 0, "R6 slow first word", got, 32'h0F0F_0F0F);
    gap_len(n);
    chk(n == 320, "R6 slow word gap", n, 320);
    grab(40, got, bad);
    chk(got == 32'h3333_CCCC && bad == 0, "R6 slow second word", got, 32'h3333_CCCC);
    tx_enable = 1'b0;
    repeat (340) @(negedge clk);
    slow_rate = 1'b0;

    // R8: enable dropped mid-word
    push(32'h0000_AAAA); push(32'h5555_0000);
    tx_enable = 1'b1;
    while (!(line_one || line_zero)) @(negedge clk);
    tx_enable = 1'b0;
    grab(5, got, bad);
    chk(got == 32'h0000_AAAA && bad == 0, "R8 word finishes after disable", got, 32'h0000_AAAA);
    quiet_for(200, act);
    chk(act == 0, "R8 no start while disabled", act, 0);
    chk(ready_o == 1'b0, "R8 word still queued", {31'd0, ready_o}, 32'd0);
    tx_enable = 1'b1;
    grab(5, got, bad);
    chk(got == 32'h5555_0000 && bad == 0, "R8 resumes on enable", got, 32'h5555_0000);
    tx_enable = 1'b0;
    repeat (60) @(negedge clk);

    // R9: forced null
    force_null = 1'b1;
    push(32'hFFFF_0000);
    tx_enable = 1'b1;
    quiet_for(400, act);
    chk(act == 0, "R9 line held null", act, 0);
    chk(ready_o == 1'b1, "R9 word consumed", {31'd0, ready_o}, 32'd1);
    tx_enable = 1'b0; force_null = 1'b0;

    // R10: reset during transmission
    push(32'h1111_1111); push(32'h2222_2222);
    tx_enable = 1'b1;
    while (!(line_one || line_zero)) @(negedge clk);
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!line_one && !line_zero, "R10 line null on reset", {30'd0, line_one, line_zero}, 32'd0);
    chk(ready_o == 1'b1 && half_room_o == 1'b1 && full_o == 1'b0, "R10 flags on reset",
        {29'd0, ready_o, half_room_o, full_o}, 32'd6);
    @(negedge clk); rst_n = 1'b1;
    quiet_for(400, act);
    chk(act == 0, "R10 queue emptied", act, 0);
    tx_enable = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule